// File: doc/BRIEF.md
# CRT Controller Register File with Timing Lock and Legacy Cursor Fix-up

This block holds the register set of a VGA-style CRT controller. A host reaches it through a shared byte bus with two strobes. One strobe loads an index register. The other writes the data bus into the register that the index currently selects. The register at the current index is always visible on a combinational read port, and reading has no side effects.

Two write filters sit in front of the register storage.

- **Timing lock.** When the lock bit is set (bit 7 of the vertical-retrace-end register at index 0x11), the eight lowest timing registers (indices 0x00 to 0x07) are protected. Bit 4 of the overflow register at index 0x07 is the one exception and stays writable.
- **Compatibility mode.** This mode is selected by a strap and by the sequencer's character-clock-width bit. It fixes up cursor-shape and scan-line writes that old colour-graphics software issues while the lock is set and a 16-line character cell is programmed. These writes are either dropped or replaced by values that suit the taller cell.

Top module: `crtc_regfile`

## Requirements
- R1: While bit 7 of register 0x11 is 1, a data write to any index from 0x00 to 0x06 leaves that register unchanged.
- R2: While bit 7 of register 0x11 is 1, a data write to index 0x07 copies bit 4 of the written byte into bit 4 of register 0x07, and the other seven bits keep their values.
- R3: The compatibility fix-ups apply only when three conditions all hold: the lock bit is 1, `compat_en` is 1, and `char_clk_8dot` is 0. If any of them fails, writes to 0x09, 0x0A and 0x0B are stored unchanged.
- R4: When the fix-ups apply and the low nibble of register 0x09 is 0xF, a write of 0x07 to index 0x09 is discarded.
- R5: When the fix-ups apply and the low nibble of register 0x09 is 0xF, a write of 0x06 to index 0x0A stores 0x0D.
- R6: When the fix-ups apply and the low nibble of register 0x09 is 0xF, a write of 0x07 to index 0x0B stores 0x0E.
- R7: Every other data write to an index from 0x00 to 0x18 stores the written byte unchanged at that index, and this includes index 0x11 while the lock is set.
- R8: An index strobe loads the full 8-bit bus into the index register, which is shown on `index_q` in the following cycle. Data writes while the index is above 0x18 change no register, and the read port then returns 0x00.
- R9: `host_rdata` always shows the register at the current index. Cycles without a data strobe change no register.
- R10: After reset, the index and all 25 registers read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| index_wr | input | 1 | Loads the index register from `host_wdata` |
| data_wr | input | 1 | Writes `host_wdata` to the register at the current index |
| host_wdata | input | 8 | Host write bus, shared by index and data |
| compat_en | input | 1 | Static strap that enables the legacy fix-ups |
| char_clk_8dot | input | 1 | Sequencer character-clock width bit (1 = 8-dot clock) |
| host_rdata | output | 8 | Register at the current index, or 0x00 when the index is out of range |
| index_q | output | 8 | Current index |

## Verification
The assertions check the following on every cycle:
- each locked low register stays stable;
- the single free overflow bit follows the write;
- each of the three fix-up outcomes is applied;
- plain writes are stored when the fix-up gate is closed;
- no register moves on an idle cycle or on an out-of-range write.

Only the bench's scenarios can show behaviour that depends on history:
- the reset contents;
- that the combinational read path selects the right register;
- that each fix-up needs the exact trigger value and a full scan nibble;
- that all eight combinations of lock, strap and clock-width bit gate the fix-ups correctly.

// File: rtl/crtc_pkg.sv
package crtc_pkg;

   // Outcome chosen by the write filter for one data strobe
   typedef enum logic [2:0] {
      WD_STORE      = 3'd0,
      WD_BLOCK      = 3'd1,
      WD_OVF_BIT    = 3'd2,
      WD_SCAN_DROP  = 3'd3,
      WD_CSTART_SUB = 3'd4,
      WD_CEND_SUB   = 3'd5,
      WD_NO_TARGET  = 3'd6
   } wr_decision_e;

   // Legacy fix-up trigger and replacement values
   localparam int unsigned SCAN_DROP_VAL = 7;
   localparam int unsigned CSTART_IN_VAL = 6;
   localparam int unsigned CSTART_OUT_VAL = 13;
   localparam int unsigned CEND_IN_VAL = 7;
   localparam int unsigned CEND_OUT_VAL = 14;

endpackage

// File: rtl/crtc_index_reg.sv
module crtc_index_reg #(
   parameter int unsigned IDX_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [IDX_W-1:0] din,
   output logic [IDX_W-1:0] q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q <= '0;
      end else if (load) begin
         q <= din;
      end
   end

endmodule

// File: rtl/crtc_write_filter.sv
module crtc_write_filter
   import crtc_pkg::*;
#(
   parameter int unsigned DATA_W       = 8,
   parameter int unsigned IDX_W        = 8,
   parameter int unsigned NUM_REGS     = 25,
   parameter int unsigned LOCK_LAST    = 7,
   parameter int unsigned OVF_IDX      = 7,
   parameter int unsigned OVF_FREE_BIT = 4,
   parameter int unsigned SCAN_IDX     = 9,
   parameter int unsigned CSTART_IDX   = 10,
   parameter int unsigned CEND_IDX     = 11,
   parameter int unsigned SCAN_FLD_W   = 4
) (
   input  logic                  wr_req,
   input  logic [IDX_W-1:0]      idx,
   input  logic [DATA_W-1:0]     wdata,
   input  logic                  locked,
   input  logic                  compat_en,
   input  logic                  char_clk_8dot,
   input  logic [SCAN_FLD_W-1:0] scan_field,
   output logic                  commit,
   output logic [DATA_W-1:0]     mask,
   output logic [DATA_W-1:0]     value,
   output wr_decision_e          decision
);

   localparam logic [IDX_W:0]    NREGS_I    = (IDX_W+1)'(NUM_REGS);
   localparam logic [IDX_W-1:0]  LOCK_LAST_I = IDX_W'(LOCK_LAST);
   localparam logic [IDX_W-1:0]  OVF_I      = IDX_W'(OVF_IDX);
   localparam logic [IDX_W-1:0]  SCAN_I     = IDX_W'(SCAN_IDX);
   localparam logic [IDX_W-1:0]  CSTART_I   = IDX_W'(CSTART_IDX);
   localparam logic [IDX_W-1:0]  CEND_I     = IDX_W'(CEND_IDX);
   localparam logic [DATA_W-1:0] FREE_MASK  = DATA_W'(1) << OVF_FREE_BIT;
   localparam logic [DATA_W-1:0] SCAN_DROP_V  = DATA_W'(SCAN_DROP_VAL);
   localparam logic [DATA_W-1:0] CSTART_IN_V  = DATA_W'(CSTART_IN_VAL);
   localparam logic [DATA_W-1:0] CSTART_OUT_V = DATA_W'(CSTART_OUT_VAL);
   localparam logic [DATA_W-1:0] CEND_IN_V    = DATA_W'(CEND_IN_VAL);
   localparam logic [DATA_W-1:0] CEND_OUT_V   = DATA_W'(CEND_OUT_VAL);

   logic fixup_gate;
   logic scan_full;
   logic in_range;

   assign fixup_gate = locked && compat_en && !char_clk_8dot;
   assign scan_full  = &scan_field;
   assign in_range   = {1'b0, idx} < NREGS_I;

   always_comb begin
      decision = WD_STORE;
      mask     = '1;
      value    = wdata;
      if (!in_range) begin
         decision = WD_NO_TARGET;
         mask     = '0;
      end else if (locked && idx <= LOCK_LAST_I) begin
         if (idx == OVF_I) begin
            decision = WD_OVF_BIT;
            mask     = FREE_MASK;
         end else begin
            decision = WD_BLOCK;
            mask     = '0;
         end
      end else if (fixup_gate && scan_full) begin
         if (idx == SCAN_I && wdata == SCAN_DROP_V) begin
            decision = WD_SCAN_DROP;
            mask     = '0;
         end else if (idx == CSTART_I && wdata == CSTART_IN_V) begin
            decision = WD_CSTART_SUB;
            value    = CSTART_OUT_V;
         end else if (idx == CEND_I && wdata == CEND_IN_V) begin
            decision = WD_CEND_SUB;
            value    = CEND_OUT_V;
         end
      end
      commit = wr_req && (mask != '0);
   end

endmodule

// File: rtl/crtc_reg_bank.sv
module crtc_reg_bank #(
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned IDX_W    = 8,
   parameter int unsigned NUM_REGS = 25
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             commit,
   input  logic [IDX_W-1:0]                 wr_idx,
   input  logic [DATA_W-1:0]                mask,
   input  logic [DATA_W-1:0]                value,
   input  logic [IDX_W-1:0]                 rd_idx,
   output logic [DATA_W-1:0]                rd_data,
   output logic [NUM_REGS-1:0][DATA_W-1:0]  regs
);

   localparam int unsigned SEL_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
   localparam logic [IDX_W:0] NREGS_I = (IDX_W+1)'(NUM_REGS);

   for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            regs[g] <= '0;
         end else if (commit && wr_idx == IDX_W'(g)) begin
            regs[g] <= (regs[g] & ~mask) | (value & mask);
         end
      end
   end

   logic [SEL_W-1:0] rd_sel;
   assign rd_sel = rd_idx[SEL_W-1:0];

   always_comb begin
      rd_data = '0;
      if ({1'b0, rd_idx} < NREGS_I) begin
         rd_data = regs[rd_sel];
      end
   end

endmodule

// File: rtl/crtc_regfile.sv
module crtc_regfile
   import crtc_pkg::*;
#(
   parameter int unsigned DATA_W       = 8,
   parameter int unsigned IDX_W        = 8,
   parameter int unsigned NUM_REGS     = 25,
   parameter int unsigned LOCK_IDX     = 17,
   parameter int unsigned LOCK_BIT     = 7,
   parameter int unsigned LOCK_LAST    = 7,
   parameter int unsigned OVF_IDX      = 7,
   parameter int unsigned OVF_FREE_BIT = 4,
   parameter int unsigned SCAN_IDX     = 9,
   parameter int unsigned CSTART_IDX   = 10,
   parameter int unsigned CEND_IDX     = 11,
   parameter int unsigned SCAN_FLD_W   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              index_wr,
   input  logic              data_wr,
   input  logic [DATA_W-1:0] host_wdata,
   input  logic              compat_en,
   input  logic              char_clk_8dot,
   output logic [DATA_W-1:0] host_rdata,
   output logic [IDX_W-1:0]  index_q
);

   // Elaboration-time parameter checks
   if (DATA_W < 8)                 begin : g_chk_dw   $error("DATA_W must be at least 8"); end
   if (IDX_W > DATA_W)             begin : g_chk_iw   $error("IDX_W must not exceed DATA_W"); end
   if (NUM_REGS > (1 << IDX_W))    begin : g_chk_nr   $error("NUM_REGS exceeds index space"); end
   if (LOCK_IDX >= NUM_REGS)       begin : g_chk_li   $error("LOCK_IDX out of range"); end
   if (LOCK_IDX <= LOCK_LAST)      begin : g_chk_ll   $error("lock register must lie above the locked span"); end
   if (LOCK_BIT >= DATA_W)         begin : g_chk_lb   $error("LOCK_BIT out of range"); end
   if (OVF_IDX > LOCK_LAST)        begin : g_chk_ov   $error("OVF_IDX must lie inside the locked span"); end
   if (OVF_FREE_BIT >= DATA_W)     begin : g_chk_fb   $error("OVF_FREE_BIT out of range"); end
   if (SCAN_FLD_W > DATA_W)        begin : g_chk_sf   $error("SCAN_FLD_W out of range"); end
   if (SCAN_IDX <= LOCK_LAST || CSTART_IDX <= LOCK_LAST || CEND_IDX <= LOCK_LAST)
                                   begin : g_chk_fx   $error("fix-up targets must lie above the locked span"); end
   if (CEND_IDX >= NUM_REGS || CSTART_IDX >= NUM_REGS || SCAN_IDX >= NUM_REGS)
                                   begin : g_chk_fr   $error("fix-up targets out of range"); end

   localparam logic [IDX_W:0] NREGS_I = (IDX_W+1)'(NUM_REGS);

   logic [NUM_REGS-1:0][DATA_W-1:0] regs;
   logic                            locked;
   logic [SCAN_FLD_W-1:0]           scan_field;
   logic                            commit;
   logic [DATA_W-1:0]               wmask;
   logic [DATA_W-1:0]               wvalue;
   wr_decision_e                    decision;

   assign locked     = regs[LOCK_IDX][LOCK_BIT];
   assign scan_field = regs[SCAN_IDX][SCAN_FLD_W-1:0];

   crtc_index_reg #(.IDX_W(IDX_W)) u_index (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (index_wr),
      .din   (host_wdata[IDX_W-1:0]),
      .q     (index_q)
   );

   crtc_write_filter #(
      .DATA_W(DATA_W), .IDX_W(IDX_W), .NUM_REGS(NUM_REGS),
      .LOCK_LAST(LOCK_LAST), .OVF_IDX(OVF_IDX), .OVF_FREE_BIT(OVF_FREE_BIT),
      .SCAN_IDX(SCAN_IDX), .CSTART_IDX(CSTART_IDX), .CEND_IDX(CEND_IDX),
      .SCAN_FLD_W(SCAN_FLD_W)
   ) u_filter (
      .wr_req        (data_wr),
      .idx           (index_q),
      .wdata         (host_wdata),
      .locked        (locked),
      .compat_en     (compat_en),
      .char_clk_8dot (char_clk_8dot),
      .scan_field    (scan_field),
      .commit        (commit),
      .mask          (wmask),
      .value         (wvalue),
      .decision      (decision)
   );

   crtc_reg_bank #(.DATA_W(DATA_W), .IDX_W(IDX_W), .NUM_REGS(NUM_REGS)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .commit  (commit),
      .wr_idx  (index_q),
      .mask    (wmask),
      .value   (wvalue),
      .rd_idx  (index_q),
      .rd_data (host_rdata),
      .regs    (regs)
   );

   // ---------------- assertions ----------------
   logic fixup_on;
   logic scan_full_now;
   assign fixup_on      = locked && compat_en && !char_clk_8dot;
   assign scan_full_now = &scan_field;

   for (genvar i = 0; i <= LOCK_LAST; i++) begin : g_lock_chk
      if (i != OVF_IDX) begin : g_hold
         assert_locked_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
            (data_wr && locked && index_q == IDX_W'(i)) |=> $stable(regs[i]));
      end
   end

   assert_ovf_free_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (data_wr && locked && index_q == IDX_W'(OVF_IDX)) |=>
         (regs[OVF_IDX][OVF_FREE_BIT] == $past(host_wdata[OVF_FREE_BIT])));

   assert_ovf_rest_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (data_wr && decision == WD_OVF_BIT) |=>
         ((regs[OVF_IDX] & ~(DATA_W'(1) << OVF_FREE_BIT)) ==
          ($past(regs[OVF_IDX]) & ~(DATA_W'(1) << OVF_FREE_BIT))));

   for (genvar i = LOCK_LAST + 1; i < NUM_REGS; i++) begin : g_gate_chk
      assert_gate_closed_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (data_wr && !fixup_on && index_q == IDX_W'(i)) |=> (regs[i] == $past(host_wdata)));
   end

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_store_chk
      assert_unlocked_store_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (data_wr && !locked && index_q == IDX_W'(i)) |=> (regs[i] == $past(host_wdata)));
   end

   assert_scan_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (data_wr && fixup_on && scan_full_now && index_q == IDX_W'(SCAN_IDX) &&
       host_wdata == DATA_W'(SCAN_DROP_VAL)) |=> $stable(regs[SCAN_IDX]));

   assert_cstart_sub_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (data_wr && fixup_on && scan_full_now && index_q == IDX_W'(CSTART_IDX) &&
       host_wdata == DATA_W'(CSTART_IN_VAL)) |=> (regs[CSTART_IDX] == DATA_W'(CSTART_OUT_VAL)));

   assert_cend_sub_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (data_wr && fixup_on && scan_full_now && index_q == IDX_W'(CEND_IDX) &&
       host_wdata == DATA_W'(CEND_IN_VAL)) |=> (regs[CEND_IDX] == DATA_W'(CEND_OUT_VAL)));

   assert_out_of_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (data_wr && !({1'b0, index_q} < NREGS_I)) |=> $stable(regs));

   assert_index_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
      index_wr |=> (index_q == $past(host_wdata[IDX_W-1:0])));

   assert_idle_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !data_wr |=> $stable(regs));

endmodule

// File: tb/tb_crtc_regfile.sv
`timescale 1ns/1ps
module tb_crtc_regfile;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       index_wr = 1'b0;
   logic       data_wr = 1'b0;
   logic [7:0] host_wdata = '0;
   logic       compat_en = 1'b0;
   logic       char_clk_8dot = 1'b0;
   logic [7:0] host_rdata;
   logic [7:0] index_q;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [7:0] mdl [0:24];
   string      last_tag;

   always #2.5 clk = ~clk;

   crtc_regfile dut (
      .clk(clk), .rst_n(rst_n), .index_wr(index_wr), .data_wr(data_wr),
      .host_wdata(host_wdata), .compat_en(compat_en), .char_clk_8dot(char_clk_8dot),
      .host_rdata(host_rdata), .index_q(index_q)
   );

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] expv, input string what);
      checks++;
      if (act !== expv) begin
         errors++;
         $display("FAIL %s %s: actual %02h expected %02h", tag, what, act, expv);
      end
   endtask

   // Reference model of a data write, taken from the requirements
   task automatic model_write(input int idx, input logic [7:0] v);
      bit lk, gate, full;
      lk   = mdl[17][7];
      gate = lk && compat_en && !char_clk_8dot;
      full = (mdl[9][3:0] == 4'hF);
      if (idx > 24) begin
         last_tag = "R8";
      end else if (lk && idx <= 7) begin
         if (idx == 7) begin
            mdl[7] = (mdl[7] & 8'hEF) | (v & 8'h10);
            last_tag = "R2";
         end else begin
            last_tag = "R1";
         end
      end else if (gate && full && idx == 9 && v == 8'h07) begin
         last_tag = "R4";
      end else if (gate && full && idx == 10 && v == 8'h06) begin
         mdl[10] = 8'h0D;
         last_tag = "R5";
      end else if (gate && full && idx == 11 && v == 8'h07) begin
         mdl[11] = 8'h0E;
         last_tag = "R6";
      end else begin
         mdl[idx] = v;
         last_tag = (lk && idx >= 9 && idx <= 11) ? "R3" : "R7";
      end
   endtask

   task automatic set_idx(input int idx);
      @(negedge clk);
      index_wr = 1'b1;
      host_wdata = 8'(idx);
      @(negedge clk);
      index_wr = 1'b0;
   endtask

   task automatic wr_at(input int idx, input logic [7:0] v);
      set_idx(idx);
      @(negedge clk);
      data_wr = 1'b1;
      host_wdata = v;
      model_write(idx, v);
      @(negedge clk);
      data_wr = 1'b0;
   endtask

   task automatic rd_chk(input int idx, input string tag);
      set_idx(idx);
      #0.5;
      check(tag, host_rdata, (idx > 24) ? 8'h00 : mdl[idx], $sformatf("read idx %02h", idx));
   endtask

   task automatic rd_all(input string tag);
      for (int i = 0; i < 25; i++) rd_chk(i, tag);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 25; i++) mdl[i] = 8'h00;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #0.5;
      // R10: reset state
      check("R10", index_q, 8'h00, "index after reset");
      check("R10", host_rdata, 8'h00, "rdata after reset");
      rd_all("R10");

      // R7: unlocked sweep, lock bit kept clear
      for (int i = 0; i < 25; i++) wr_at(i, 8'((i * 29 + 3) & ((i == 17) ? 8'h7F : 8'hFF)));
      rd_all("R7");

      // R8: index load and out-of-range writes
      foreach (mdl[k]) ;
      for (int j = 0; j < 4; j++) begin
         int oi;
         oi = (j == 0) ? 25 : (j == 1) ? 32 : (j == 2) ? 128 : 255;
         wr_at(oi, 8'hA5);
         #0.5;
         check("R8", index_q, 8'(oi), "index readback");
         check("R8", host_rdata, 8'h00, "out-of-range read");
      end
      rd_all("R8");

      // R1 / R2: lock the low timing registers
      wr_at(17, 8'h80);
      for (int i = 0; i < 8; i++) begin
         wr_at(i, ~mdl[i]);
         rd_chk(i, last_tag);
      end
      wr_at(7, 8'hFF);
      rd_chk(7, "R2");
      wr_at(7, 8'h00);
      rd_chk(7, "R2");
      wr_at(17, 8'hC3);
      rd_chk(17, "R7");

      // R3..R6: fix-up gating across all lock/strap/clock combinations
      for (int c = 0; c < 8; c++) begin
         bit lk;
         lk = c[0];
         wr_at(17, 8'h00);
         compat_en = c[1];
         char_clk_8dot = c[2];
         wr_at(9, 8'h0F);
         wr_at(10, 8'h00);
         wr_at(11, 8'h00);
         wr_at(17, lk ? 8'h80 : 8'h00);
         wr_at(10, 8'h06); rd_chk(10, last_tag);
         wr_at(11, 8'h07); rd_chk(11, last_tag);
         wr_at(9, 8'h07);  rd_chk(9, last_tag);
         // non-trigger values pass through
         wr_at(10, 8'h05); rd_chk(10, last_tag);
         wr_at(11, 8'h06); rd_chk(11, last_tag);
      end

      // Fix-ups need a full scan nibble
      compat_en = 1'b1;
      char_clk_8dot = 1'b0;
      wr_at(17, 8'h00);
      wr_at(9, 8'h1E);
      wr_at(17, 8'h80);
      wr_at(10, 8'h06); rd_chk(10, "R7");
      wr_at(11, 8'h07); rd_chk(11, "R7");
      wr_at(9, 8'h07);  rd_chk(9, "R7");
      wr_at(9, 8'h2F);  rd_chk(9, "R7");
      wr_at(9, 8'h07);  rd_chk(9, "R4");
      wr_at(10, 8'h06); rd_chk(10, "R5");
      wr_at(11, 8'h07); rd_chk(11, "R6");

      // R9: repeated reads and idle cycles leave everything intact
      for (int r = 0; r < 3; r++) rd_chk(10, "R9");
      repeat (10) @(negedge clk);
      rd_all("R9");

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule